// File: doc/BRIEF.md
# Transmit IP Frame Length Checker

This block watches a transmit Ethernet frame while it streams past, one byte per accepted cycle, marked by a valid strobe and by start and end flags. It finds the length/type field and the IPv4 or IPv6 header that follows it. It then checks that the declared header and payload lengths agree with the bytes that actually arrived. It produces two verdicts per frame: a header error and a payload error.

The frame is untagged and carries no CRC. The IP header starts at byte 14. The block keeps only the few header fields it needs plus a running byte position, so it adds nothing to the data path. One cycle after the last byte it reports both flags and a summary bit. The summary also folds in error inputs that other transmit logic supplies with the last byte.

Top module: `ip_len_checker`

## Requirements
- R1: Byte positions count from 0 at the byte flagged as start. The length/type field is bytes 12 and 13, high byte first. Byte 14 holds the IP version in its upper nibble. For IPv4, the lower nibble of byte 14 is the header length in 32-bit words, bytes 16-17 are the total length and byte 23 is the protocol. For IPv6, bytes 18-19 are the payload length and byte 20 is the next-header value.
- R2: A header error is raised when the length/type is 0x0800 and the version is not 4, or when it is 0x86DD and the version is not 6.
- R3: With length/type 0x0800, a header-length nibble below 5 raises a header error.
- R4: With length/type 0x0800, a frame shorter than 14 + 4 × header-length bytes raises a header error. This includes a frame that ends at or before byte 14.
- R5: With length/type 0x86DD, a frame shorter than 54 bytes (40-byte main header not complete) raises a header error.
- R6: For IPv4 with protocol 1, 6, 17 or 58, a payload error is raised in either of two cases. One is that total length minus 4 × header-length differs from the number of bytes after the header. The other is that total length is below 4 × header-length.
- R7: For IPv6 with next-header 1, 6, 17 or 58, a payload error is raised when the payload length field differs from the number of bytes after byte 53.
- R8: No error is raised in three cases: other protocol numbers, length/type values other than 0x0800 and 0x86DD, and frames shorter than 14 bytes.
- R9: When a header error is raised for a frame, its payload error is 0.
- R10: res_valid is high for exactly the one cycle after the end byte is accepted. The flags are updated at that point. They hold until the next accepted start byte, which clears them (an end flag on the same byte wins).
- R11: err_sum is the OR of hdr_err, pay_err and every ext_err bit sampled with the end byte.
- R12: Cycles with in_valid low change nothing, whatever in_data, in_sof and in_eof carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A stream byte is present |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| ext_err | input | EXT_W | Other transmit errors, sampled with the end byte |
| res_valid | output | 1 | One-cycle pulse after the end byte |
| hdr_err | output | 1 | Header error for the last frame |
| pay_err | output | 1 | Payload error for the last frame |
| err_sum | output | 1 | OR of all errors for the last frame |

## Verification
The bench sends correct IPv4 frames, with and without options, and a correct IPv6 frame. Both must stay clean. It then alters one thing at a time: the version nibble, the header-length nibble, the total or payload length, and the frame cut-off point. This shows that each header rule and each payload rule fires on its own cause and that a header error masks the payload check. Frames with untracked protocols, non-IP types and very short lengths separate "not checked" from "checked and wrong". A frame with idle gaps carrying junk control flags shows that only accepted bytes count. A flag held across idle cycles and then cleared by a lone start byte pins down the result timing.

// File: rtl/ipchk_pkg.sv
package ipchk_pkg;

    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [15:0] ETYPE_IPV6 = 16'h86DD;
    localparam int          IP_OFS     = 14;
    localparam int          V6_HDR_LEN = 40;
    localparam int          N_TRACKED  = 4;

    // transport protocols whose byte count is checked
    localparam logic [7:0] TRACKED_PROTO [N_TRACKED] = '{8'd1, 8'd6, 8'd17, 8'd58};

    typedef struct packed {
        logic [15:0] etype;
        logic [3:0]  ver;
        logic [3:0]  ihl;
        logic [15:0] v4_total;
        logic [7:0]  v4_proto;
        logic [15:0] v6_plen;
        logic [7:0]  v6_next;
    } hdr_fields_t;

endpackage

// File: rtl/ipchk_pos_count.sv
module ipchk_pos_count #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    output logic [LEN_W-1:0] cur_pos,
    output logic [LEN_W:0]   cur_len
);

    localparam logic [LEN_W-1:0] POS_MAX = '1;

    typedef struct packed {
        logic [LEN_W-1:0] pos;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        cur_pos = in_sof ? '0 : st_q.pos;
        cur_len = {1'b0, cur_pos} + 1'b1;
        if (in_valid) begin
            if (cur_pos != POS_MAX) begin
                st_d.pos = cur_pos + 1'b1;
            end else begin
                st_d.pos = cur_pos;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ipchk_field_cap.sv
module ipchk_field_cap
    import ipchk_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [7:0]       in_data,
    input  logic [LEN_W-1:0] cur_pos,
    output hdr_fields_t      fld_now
);

    localparam logic [LEN_W-1:0] P_ET_HI = LEN_W'(12);
    localparam logic [LEN_W-1:0] P_ET_LO = LEN_W'(13);
    localparam logic [LEN_W-1:0] P_VER   = LEN_W'(IP_OFS);
    localparam logic [LEN_W-1:0] P_TL_HI = LEN_W'(IP_OFS + 2);
    localparam logic [LEN_W-1:0] P_TL_LO = LEN_W'(IP_OFS + 3);
    localparam logic [LEN_W-1:0] P_PL_HI = LEN_W'(IP_OFS + 4);
    localparam logic [LEN_W-1:0] P_PL_LO = LEN_W'(IP_OFS + 5);
    localparam logic [LEN_W-1:0] P_NH    = LEN_W'(IP_OFS + 6);
    localparam logic [LEN_W-1:0] P_PROTO = LEN_W'(IP_OFS + 9);

    hdr_fields_t fld_d, fld_q;

    always_comb begin
        fld_d = fld_q;
        if (in_valid) begin
            if (in_sof) begin
                fld_d = '0;
            end
            if (cur_pos == P_ET_HI) fld_d.etype[15:8]    = in_data;
            if (cur_pos == P_ET_LO) fld_d.etype[7:0]     = in_data;
            if (cur_pos == P_VER) begin
                fld_d.ver = in_data[7:4];
                fld_d.ihl = in_data[3:0];
            end
            if (cur_pos == P_TL_HI) fld_d.v4_total[15:8] = in_data;
            if (cur_pos == P_TL_LO) fld_d.v4_total[7:0]  = in_data;
            if (cur_pos == P_PL_HI) fld_d.v6_plen[15:8]  = in_data;
            if (cur_pos == P_PL_LO) fld_d.v6_plen[7:0]   = in_data;
            if (cur_pos == P_NH)    fld_d.v6_next        = in_data;
            if (cur_pos == P_PROTO) fld_d.v4_proto       = in_data;
        end
        fld_now = fld_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q <= '0;
        end else begin
            fld_q <= fld_d;
        end
    end

endmodule

// File: rtl/ipchk_verdict.sv
module ipchk_verdict
    import ipchk_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  hdr_fields_t    fld,
    input  logic [LEN_W:0] flen,
    output logic           hdr_bad,
    output logic           pay_bad
);

    localparam int          LW       = LEN_W + 1;
    localparam logic [LW-1:0] ETH_LEN = LW'(IP_OFS);
    localparam logic [LW-1:0] VER_LEN = LW'(IP_OFS + 1);
    localparam logic [LW-1:0] V6_NEED = LW'(IP_OFS + V6_HDR_LEN);

    logic            is_eth, is_v4, is_v6;
    logic [LW-1:0]   v4_hbytes, v4_need, v4_decl, v4_seen, v6_seen;
    logic            v4_bad, v6_bad, v4_under;
    logic [7:0]      proto;
    logic [N_TRACKED-1:0] proto_hit;
    logic            tracked;

    // one comparator per tracked protocol number
    for (genvar g = 0; g < N_TRACKED; g++) begin : g_proto
        assign proto_hit[g] = (proto == TRACKED_PROTO[g]);
    end

    always_comb begin
        is_eth    = (flen >= ETH_LEN);
        is_v4     = (fld.etype == ETYPE_IPV4);
        is_v6     = (fld.etype == ETYPE_IPV6);
        v4_hbytes = LW'({fld.ihl, 2'b00});
        v4_need   = ETH_LEN + v4_hbytes;
        proto     = is_v4 ? fld.v4_proto : fld.v6_next;
        tracked   = |proto_hit;

        v4_bad = (flen < VER_LEN) || (fld.ver != 4'd4) ||
                 (fld.ihl < 4'd5) || (flen < v4_need);
        v6_bad = (fld.ver != 4'd6) || (flen < V6_NEED);

        v4_under = (LW'(fld.v4_total) < v4_hbytes);
        v4_decl  = LW'(fld.v4_total) - v4_hbytes;
        v4_seen  = flen - v4_need;
        v6_seen  = flen - V6_NEED;

        hdr_bad = is_eth && ((is_v4 && v4_bad) || (is_v6 && v6_bad));

        pay_bad = 1'b0;
        if (is_eth && !hdr_bad && tracked) begin
            if (is_v4) begin
                pay_bad = v4_under || (v4_seen != v4_decl);
            end else if (is_v6) begin
                pay_bad = (v6_seen != LW'(fld.v6_plen));
            end
        end
    end

endmodule

// File: rtl/ip_len_checker.sv
module ip_len_checker
    import ipchk_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int EXT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [EXT_W-1:0] ext_err,
    output logic             res_valid,
    output logic             hdr_err,
    output logic             pay_err,
    output logic             err_sum
);

    typedef struct packed {
        logic vld;
        logic hdr;
        logic pay;
        logic ext;
    } res_state_t;

    logic [LEN_W-1:0] cur_pos;
    logic [LEN_W:0]   cur_len;
    hdr_fields_t      fld_now;
    logic             hdr_bad, pay_bad;
    res_state_t       res_d, res_q;

    ipchk_pos_count #(.LEN_W(LEN_W)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .cur_pos  (cur_pos),
        .cur_len  (cur_len)
    );

    ipchk_field_cap #(.LEN_W(LEN_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_data  (in_data),
        .cur_pos  (cur_pos),
        .fld_now  (fld_now)
    );

    ipchk_verdict #(.LEN_W(LEN_W)) u_verdict (
        .fld     (fld_now),
        .flen    (cur_len),
        .hdr_bad (hdr_bad),
        .pay_bad (pay_bad)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = in_valid && in_eof;
        if (in_valid && in_eof) begin
            res_d.hdr = hdr_bad;
            res_d.pay = pay_bad;
            res_d.ext = |ext_err;
        end else if (in_valid && in_sof) begin
            res_d.hdr = 1'b0;
            res_d.pay = 1'b0;
            res_d.ext = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.vld;
    assign hdr_err   = res_q.hdr;
    assign pay_err   = res_q.pay;
    assign err_sum   = res_q.hdr | res_q.pay | res_q.ext;

endmodule

// File: rtl/ip_len_checker_sva.sv
module ip_len_checker_sva #(
    parameter int EXT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sof,
    input logic             in_eof,
    input logic [EXT_W-1:0] ext_err,
    input logic             res_valid,
    input logic             hdr_err,
    input logic             pay_err,
    input logic             err_sum
);

    a_r10_pulse_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof) |=> res_valid);

    a_r10_no_pulse_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_eof) |=> !res_valid);

    a_r12_idle_holds_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(hdr_err) && $stable(pay_err) && $stable(err_sum)));

    a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !in_eof) |=> (!hdr_err && !pay_err && !err_sum));

    a_r9_header_masks_payload: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |-> !pay_err);

    a_r11_summary_covers_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_err || pay_err) |-> err_sum);

    a_r11_external_reaches_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof && (|ext_err)) |=> err_sum);

endmodule

bind ip_len_checker ip_len_checker_sva #(.EXT_W(EXT_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .ext_err   (ext_err),
    .res_valid (res_valid),
    .hdr_err   (hdr_err),
    .pay_err   (pay_err),
    .err_sum   (err_sum)
);

// File: tb/ip_len_checker_test.sv
module ip_len_checker_test;

    localparam int EXT_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = '0;
    logic             in_sof = 1'b0;
    logic             in_eof = 1'b0;
    logic [EXT_W-1:0] ext_err = '0;
    logic             res_valid, hdr_err, pay_err, err_sum;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [7:0] fb [0:511];
    int         fl;

    always #10 clk = ~clk;

    ip_len_checker #(.LEN_W(16), .EXT_W(EXT_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .ext_err(ext_err),
        .res_valid(res_valid), .hdr_err(hdr_err), .pay_err(pay_err), .err_sum(err_sum)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        fb[fl] = b;
        fl++;
    endtask

    task automatic eth_hdr(input logic [15:0] etype);
        fl = 0;
        for (int i = 0; i < 12; i++) put(8'hA0 + 8'(i));
        put(etype[15:8]);
        put(etype[7:0]);
    endtask

    task automatic v4_hdr(input logic [3:0] ver, input logic [3:0] ihl, input logic [15:0] total,
                          input logic [7:0] proto, input int hbytes);
        put({ver, ihl}); put(8'h00); put(total[15:8]); put(total[7:0]);
        put(8'h12); put(8'h34); put(8'h40); put(8'h00); put(8'h40); put(proto);
        for (int k = 10; k < hbytes; k++) put(8'h50 + 8'(k));
    endtask

    task automatic v6_hdr(input logic [3:0] ver, input logic [15:0] plen, input logic [7:0] nh);
        put({ver, 4'h0}); put(8'h00); put(8'h00); put(8'h00);
        put(plen[15:8]); put(plen[7:0]); put(nh); put(8'h40);
        for (int k = 8; k < 40; k++) put(8'h20 + 8'(k));
    endtask

    task automatic body(input int n);
        for (int k = 0; k < n; k++) put(8'(k * 7 + 3));
    endtask

    // drives fb[0..fl-1]; optional idle gaps carry junk control and data
    task automatic send(input bit gaps, input logic [EXT_W-1:0] ext);
        for (int i = 0; i < fl; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0; in_data = 8'hFF; in_sof = 1'b1; in_eof = 1'b1; ext_err = '1;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = fb[i];
            in_sof   = (i == 0);
            in_eof   = (i == fl - 1);
            ext_err  = (i == fl - 1) ? ext : '0;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; ext_err = '0; in_data = '0;
    endtask

    task automatic run(input string req, input bit gaps, input logic [EXT_W-1:0] ext,
                       input logic eh, input logic ep, input logic es);
        send(gaps, ext);
        chk(req, "res_valid pulse", res_valid, 1'b1);
        chk(req, "hdr_err", hdr_err, eh);
        chk(req, "pay_err", pay_err, ep);
        chk(req, "err_sum", err_sum, es);
        @(negedge clk);
        chk("R10", "res_valid one cycle", res_valid, 1'b0);
        chk("R10", "hdr_err held", hdr_err, eh);
    endtask

    task automatic t_reset;
        chk("R10", "reset res_valid", res_valid, 1'b0);
        chk("R10", "reset hdr_err", hdr_err, 1'b0);
        chk("R10", "reset pay_err", pay_err, 1'b0);
        chk("R11", "reset err_sum", err_sum, 1'b0);
    endtask

    task automatic t_v4_good;
        eth_hdr(16'h0800); v4_hdr(4'd4, 4'd5, 16'd50, 8'd6, 20); body(30);
        run("R1 R6 v4 tcp ok", 1'b0, '0, 1'b0, 1'b0, 1'b0);
        eth_hdr(16'h0800); v4_hdr(4'd4, 4'd6, 16'd34, 8'd17, 24); body(10);
        run("R6 v4 udp options ok", 1'b0, '0, 1'b0, 1'b0, 1'b0);
        eth_hdr(16'h0800); v4_hdr(4'd4, 4'd5, 16'd20, 8'd1, 20);
        run("R4 R6 v4 exact header no payload", 1'b0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_v4_payload;
        eth_hdr(16'h0800); v4_hdr(4'd4, 4'd5, 16'd50, 8'd6, 20); body(29);
        run("R6 v4 short payload", 1'b0, '0, 1'b0, 1'b1, 1'b1);
        eth_hdr(16'h0800); v4_hdr(4'd4, 4'd5, 16'd10, 8'd17, 20);
        run("R6 v4 total below header", 1'b0, '0, 1'b0, 1'b1, 1'b1);
        eth_hdr(16'h0800); v4_hdr(4'd4, 4'd5, 16'd40, 8'd58, 20); body(21);
        run("R6 v4 proto 58 long payload", 1'b0, '0, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_v4_header;
        eth_hdr(16'h0800); v4_hdr(4'd4, 4'd4, 16'd30, 8'd6, 20); body(10);
        run("R3 R9 ihl below five", 1'b0, '0, 1'b1, 1'b0, 1'b1);
        eth_hdr(16'h0800); v4_hdr(4'd6, 4'd5, 16'd30, 8'd6, 20); body(10);
        run("R2 v4 type version 6", 1'b0, '0, 1'b1, 1'b0, 1'b1);
        eth_hdr(16'h0800); v4_hdr(4'd4, 4'd8, 16'd60, 8'd6, 32);
        fl = 14 + 25;
        run("R4 R9 v4 header cut short", 1'b0, '0, 1'b1, 1'b0, 1'b1);
        eth_hdr(16'h0800);
        run("R4 v4 type ends at byte 13", 1'b0, '0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_v6;
        eth_hdr(16'h86DD); v6_hdr(4'd6, 16'd12, 8'd17); body(12);
        run("R1 R7 v6 udp ok", 1'b0, '0, 1'b0, 1'b0, 1'b0);
        eth_hdr(16'h86DD); v6_hdr(4'd6, 16'd12, 8'd58); body(8);
        run("R7 v6 icmp short payload", 1'b0, '0, 1'b0, 1'b1, 1'b1);
        eth_hdr(16'h86DD); v6_hdr(4'd6, 16'd12, 8'd6);
        fl = 14 + 30;
        run("R5 v6 header cut short", 1'b0, '0, 1'b1, 1'b0, 1'b1);
        eth_hdr(16'h86DD); v6_hdr(4'd4, 16'd4, 8'd6); body(4);
        run("R2 v6 type version 4", 1'b0, '0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_untracked;
        eth_hdr(16'h0800); v4_hdr(4'd4, 4'd5, 16'd100, 8'd50, 20); body(5);
        run("R8 other protocol", 1'b0, '0, 1'b0, 1'b0, 1'b0);
        eth_hdr(16'h0806); body(28);
        run("R8 non-ip type", 1'b0, '0, 1'b0, 1'b0, 1'b0);
        eth_hdr(16'h0800); fl = 10;
        run("R8 frame under 14 bytes", 1'b0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_external;
        eth_hdr(16'h0800); v4_hdr(4'd4, 4'd5, 16'd28, 8'd6, 20); body(8);
        run("R11 external error only", 1'b0, 2'b10, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_gaps;
        eth_hdr(16'h0800); v4_hdr(4'd4, 4'd5, 16'd36, 8'd17, 20); body(16);
        run("R12 idle gaps with junk", 1'b1, '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_hold_clear;
        eth_hdr(16'h0800); v4_hdr(4'd4, 4'd3, 16'd30, 8'd6, 20); body(10);
        run("R3 error before hold", 1'b0, '0, 1'b1, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk("R10", "hdr_err held over idle", hdr_err, 1'b1);
        chk("R10", "err_sum held over idle", err_sum, 1'b1);
        in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b0; in_data = 8'hA0;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        chk("R10", "start byte clears hdr_err", hdr_err, 1'b0);
        chk("R10", "start byte clears err_sum", err_sum, 1'b0);
        chk("R10", "no pulse on start byte", res_valid, 1'b0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=below 100000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_v4_good();
        t_v4_payload();
        t_v4_header();
        t_v6();
        t_untracked();
        t_external();
        t_gaps();
        t_hold_clear();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule